// File: doc/BRIEF.md
# Phase-frequency detector with polarity select

This block is the digital heart of a frequency synthesizer loop. It takes two divided pulse trains, a reference and a feedback, both as levels synchronous to a fast system clock. It detects their rising edges and keeps a two-state memory of which train fired first. The block turns that state into three kinds of output.

The first kind is a pair of charge-pump drives. Each drive is a value with an output enable, which models a three-state pin. The first drive is always live. The second drives only while the latch input is high. The second kind is a pair of logic-level comparator signals for an external pump: an active-high "down" signal and an active-low "up" signal. The third kind is a monitor pin that repeats one of the two divider outputs.

A polarity input flips the sense of the pumps and the comparator signals and chooses which divider reaches the monitor. The polarity input suits loops whose oscillator tunes in either direction. A power-save input places both pump drives in high impedance and holds the detector idle. A lock flag rises once the reference has produced a set number of edges with the detector idle the whole time.

Top module: `pfd_polsel`

## Requirements
- R1: While `rst_n` is low, and directly after it is released, both pump enables are 0, both pump values are 0, `cmp_dn` is 0, `cmp_up_n` is 1 and `lock_det` is 0.
- R2: With `pol_sel`=1, a reference rising edge seen while the detector is idle makes the pumps drive 1 (enable 1, value 1), `cmp_dn`=0 and `cmp_up_n`=0. These values appear one clock after the edge is sampled.
- R3: With `pol_sel`=1, a feedback rising edge seen while the detector is idle makes the pumps drive 0 (enable 1, value 0), `cmp_dn`=1 and `cmp_up_n`=1.
- R4: When the detector is idle, both pump enables are 0, both pump values are 0, `cmp_dn`=0 and `cmp_up_n`=1, for either polarity. Reference and feedback edges sampled in the same clock leave the detector idle.
- R5: With `pol_sel`=0, a leading reference gives pump value 0, `cmp_dn`=1 and `cmp_up_n`=1. A leading feedback gives pump value 1, `cmp_dn`=0 and `cmp_up_n`=0. The pump is enabled in both cases.
- R6: The detector returns to idle on the clock that samples the lagging train's rising edge. Its outputs show the idle values one clock later.
- R7: `pump2_oe` and `pump2_val` equal `pump1_oe` and `pump1_val` while `latch_en`=1. `pump2_oe` is 0 while `latch_en`=0.
- R8: While `pwr_save`=1, both pump enables are 0. Divider edges sampled during power save are ignored and clear the detector and the lock count. After power save ends, the detector starts idle.
- R9: `mon_out` equals `ref_div` when `pol_sel`=1 and `fb_div` when `pol_sel`=0, with no clock delay.
- R10: `lock_det` goes to 1 on the LOCK_CYCLES-th consecutive reference rising edge during which the detector stays idle (default 4). It returns to 0 on the clock where the detector leaves idle.
- R11: A further rising edge of the leading train, seen while the detector already holds that train's state, leaves that state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pol_sel | input | 1 | Polarity select: 1 normal sense, 0 inverted sense and monitor shows feedback |
| latch_en | input | 1 | Enables the second pump drive |
| pwr_save | input | 1 | Power-save request, active high |
| ref_div | input | 1 | Divided reference pulse train |
| fb_div | input | 1 | Divided feedback pulse train |
| pump1_oe | output | 1 | First pump drive enable (0 = high impedance) |
| pump1_val | output | 1 | First pump drive value |
| pump2_oe | output | 1 | Second pump drive enable |
| pump2_val | output | 1 | Second pump drive value |
| cmp_dn | output | 1 | Comparator output, active-high down |
| cmp_up_n | output | 1 | Comparator output, active-low up |
| mon_out | output | 1 | Divider monitor |
| lock_det | output | 1 | Lock flag |

## Verification
The hardest state to reach is lock followed by an immediate loss of lock. The lock count must first be walked up through coincident edges. Every earlier case in the run (leading trains, power save) clears it, so this case can only come at the end. The stimulus therefore ends the vector walk with four coincident edge pairs, which raise the flag. A lone reference edge then follows and must drop the flag on the same clock that the pump turns on. A second case is a repeated edge of the leading train while the detector already holds that train's state. The walk sets this up with the inverted polarity in force, so that the frequency-detect hold is checked against the swapped output sense.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

   // One three-state pump lane: enable plus driven value
   typedef struct packed {
      logic oe;
      logic val;
   } pump_drv_t;

   // Detector memory: which train fired first
   typedef struct packed {
      logic up;
      logic dn;
   } pfd_state_t;

   localparam int unsigned PFD_LANES = 2;   // reference lane 0, feedback lane 1

endpackage

// File: rtl/pfd_edge.sv
// Synchronous rising-edge detector, one register per lane
module pfd_edge #(
   parameter int unsigned LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] lvl,
   output logic [LANES-1:0] rise
);

   if (LANES < 1) begin : g_bad_lanes
      $error("pfd_edge: LANES must be at least 1");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= lvl[i];
      end

      assign rise[i] = lvl[i] & ~prev_q;
   end

endmodule

// File: rtl/pfd_core.sv
// Two-flop phase-frequency memory; cleared when both sides have fired
module pfd_core
   import pfd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hold,
   input  logic       ref_rise,
   input  logic       fb_rise,
   output pfd_state_t st,
   output logic       fire_nx
);

   pfd_state_t st_q, st_nx;
   logic       up_set, dn_set, both;

   always_comb begin
      up_set   = st_q.up | ref_rise;
      dn_set   = st_q.dn | fb_rise;
      both     = up_set & dn_set;
      st_nx.up = ~hold & up_set & ~both;
      st_nx.dn = ~hold & dn_set & ~both;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= st_nx;
   end

   assign st      = st_q;
   assign fire_nx = st_nx.up | st_nx.dn;

endmodule

// File: rtl/pfd_lock.sv
// Counts quiet reference edges; flag when the count reaches LOCK_CYCLES
module pfd_lock #(
   parameter int unsigned LOCK_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic busy,
   input  logic ref_rise,
   output logic locked
);

   localparam int unsigned CNT_W = $clog2(LOCK_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LOCK_CYCLES);

   if (LOCK_CYCLES < 1) begin : g_bad_lock
      $error("pfd_lock: LOCK_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           cnt_q <= '0;
      else if (hold || busy)                cnt_q <= '0;
      else if (ref_rise && cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
   end

   assign locked = (cnt_q == CNT_TOP);

endmodule

// File: rtl/pfd_map.sv
// Polarity mapping of detector state onto pump lanes and comparator pins
module pfd_map
   import pfd_pkg::*;
#(
   parameter int unsigned PUMPS = 2
) (
   input  pfd_state_t            st,
   input  logic                  pol_sel,
   input  logic                  pwr_save,
   input  logic [PUMPS-1:0]      lane_en,
   output pump_drv_t [PUMPS-1:0] pump,
   output logic                  cmp_dn,
   output logic                  cmp_up_n
);

   if (PUMPS < 1) begin : g_bad_pumps
      $error("pfd_map: PUMPS must be at least 1");
   end

   logic drv_hi, drv_lo;

   always_comb begin
      drv_hi = pol_sel ? st.up : st.dn;
      drv_lo = pol_sel ? st.dn : st.up;
   end

   for (genvar i = 0; i < PUMPS; i++) begin : g_pump
      logic live;
      assign live        = lane_en[i] & ~pwr_save;
      assign pump[i].oe  = live & (drv_hi | drv_lo);
      assign pump[i].val = live & drv_hi;
   end

   assign cmp_dn   = drv_lo;
   assign cmp_up_n = ~drv_hi;

endmodule

// File: rtl/pfd_polsel.sv
module pfd_polsel
   import pfd_pkg::*;
#(
   parameter int unsigned LOCK_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pol_sel,
   input  logic latch_en,
   input  logic pwr_save,
   input  logic ref_div,
   input  logic fb_div,
   output logic pump1_oe,
   output logic pump1_val,
   output logic pump2_oe,
   output logic pump2_val,
   output logic cmp_dn,
   output logic cmp_up_n,
   output logic mon_out,
   output logic lock_det
);

   localparam int unsigned PUMPS = 2;

   logic [PFD_LANES-1:0]  lvl, rise;
   pfd_state_t            st;
   logic                  fire_nx, busy;
   pump_drv_t [PUMPS-1:0] pump;
   logic [PUMPS-1:0]      lane_en;

   assign lvl = {fb_div, ref_div};

   pfd_edge #(.LANES(PFD_LANES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl),
      .rise  (rise)
   );

   pfd_core u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (pwr_save),
      .ref_rise (rise[0]),
      .fb_rise  (rise[1]),
      .st       (st),
      .fire_nx  (fire_nx)
   );

   assign busy = st.up | st.dn | fire_nx;

   pfd_lock #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (pwr_save),
      .busy     (busy),
      .ref_rise (rise[0]),
      .locked   (lock_det)
   );

   assign lane_en = {latch_en, 1'b1};

   pfd_map #(.PUMPS(PUMPS)) u_map (
      .st       (st),
      .pol_sel  (pol_sel),
      .pwr_save (pwr_save),
      .lane_en  (lane_en),
      .pump     (pump),
      .cmp_dn   (cmp_dn),
      .cmp_up_n (cmp_up_n)
   );

   assign pump1_oe  = pump[0].oe;
   assign pump1_val = pump[0].val;
   assign pump2_oe  = pump[1].oe;
   assign pump2_val = pump[1].val;
   assign mon_out   = pol_sel ? ref_div : fb_div;

endmodule

// File: rtl/pfd_polsel_chk.sv
module pfd_polsel_chk (
   input logic clk,
   input logic rst_n,
   input logic latch_en,
   input logic pwr_save,
   input logic pump1_oe,
   input logic pump1_val,
   input logic pump2_oe,
   input logic pump2_val,
   input logic cmp_dn,
   input logic cmp_up_n,
   input logic lock_det
);

   AST_PUMP2_OFF_UNLATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_en |-> !pump2_oe); // R7

   AST_PUMP2_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      latch_en |-> (pump2_oe == pump1_oe && pump2_val == pump1_val)); // R7

   AST_PSAVE_HIGHZ: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_save |-> (!pump1_oe && !pump2_oe)); // R8

   AST_PSAVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_save |=> (!cmp_dn && cmp_up_n)); // R8

   AST_CMP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmp_dn && !cmp_up_n)); // R5

   AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmp_dn && cmp_up_n) |-> (!pump1_oe && !pump1_val)); // R4

   AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      lock_det |-> (!pump1_oe && !cmp_dn && cmp_up_n)); // R10

endmodule

bind pfd_polsel pfd_polsel_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .latch_en  (latch_en),
   .pwr_save  (pwr_save),
   .pump1_oe  (pump1_oe),
   .pump1_val (pump1_val),
   .pump2_oe  (pump2_oe),
   .pump2_val (pump2_val),
   .cmp_dn    (cmp_dn),
   .cmp_up_n  (cmp_up_n),
   .lock_det  (lock_det)
);

// File: tb/tb_pfd_polsel.sv
module tb_pfd_polsel;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic rst_n, pol_sel, latch_en, pwr_save, ref_div, fb_div;
   logic pump1_oe, pump1_val, pump2_oe, pump2_val;
   logic cmp_dn, cmp_up_n, mon_out, lock_det;

   int total = 0;
   int bad   = 0;

   pfd_polsel dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pol_sel   (pol_sel),
      .latch_en  (latch_en),
      .pwr_save  (pwr_save),
      .ref_div   (ref_div),
      .fb_div    (fb_div),
      .pump1_oe  (pump1_oe),
      .pump1_val (pump1_val),
      .pump2_oe  (pump2_oe),
      .pump2_val (pump2_val),
      .cmp_dn    (cmp_dn),
      .cmp_up_n  (cmp_up_n),
      .mon_out   (mon_out),
      .lock_det  (lock_det)
   );

   // Vector: inputs {pol,latch,psave,ref,fb} then expected
   // {p1oe,p1val,p2oe,p2val,cmp_dn,cmp_up_n,mon,lock}
   localparam int NV = 31;
   localparam logic [12:0] VEC [NV] = '{
      13'b11010_11110010, // 0  ref leads, pol 1: R2
      13'b11000_11110000, // 1  held
      13'b11001_00000100, // 2  lagging fb clears: R6
      13'b11000_00000100, // 3  idle: R4
      13'b11001_10101100, // 4  fb leads: R3
      13'b10001_10001100, // 5  latch low, pump2 off: R7
      13'b11010_00000110, // 6  ref clears: R6
      13'b11000_00000100, // 7
      13'b01010_10101100, // 8  pol 0 ref leads, mon=fb: R5 R9
      13'b01011_00000110, // 9  clears
      13'b01000_00000100, // 10
      13'b01001_11110010, // 11 pol 0 fb leads: R5
      13'b01000_11110000, // 12
      13'b01001_11110010, // 13 repeated fb edge holds: R11
      13'b01011_00000110, // 14 ref clears
      13'b01000_00000100, // 15
      13'b11110_00000110, // 16 power save ignores edge: R8
      13'b11100_00000100, // 17
      13'b11000_00000100, // 18 restarts idle: R8
      13'b11001_10101100, // 19 recovery
      13'b11010_00000110, // 20
      13'b11000_00000100, // 21
      13'b11011_00000110, // 22 coincident edges stay idle: R4, count 1
      13'b11000_00000100, // 23
      13'b11011_00000110, // 24 count 2
      13'b11000_00000100, // 25
      13'b11011_00000110, // 26 count 3
      13'b11000_00000100, // 27
      13'b11011_00000111, // 28 count 4, lock: R10
      13'b11000_00000101, // 29 lock held
      13'b11010_11110010  // 30 lone ref edge drops lock: R10
   };

   task automatic check(input string tag, input int step, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s step %0d act=%0b exp=%0b", tag, step, act, exp);
      end
   endtask

   task automatic check_idle(input string tag);
      check({tag, " pump1_oe"},  -1, pump1_oe,  1'b0);
      check({tag, " pump1_val"}, -1, pump1_val, 1'b0);
      check({tag, " pump2_oe"},  -1, pump2_oe,  1'b0);
      check({tag, " cmp_dn"},    -1, cmp_dn,    1'b0);
      check({tag, " cmp_up_n"},  -1, cmp_up_n,  1'b1);
      check({tag, " lock_det"},  -1, lock_det,  1'b0);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stim
      rst_n = 1'b0; pol_sel = 1'b1; latch_en = 1'b1; pwr_save = 1'b0;
      ref_div = 1'b0; fb_div = 1'b0;
      repeat (3) @(posedge clk);
      #5;
      check_idle("R1 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #5;
      check_idle("R1 after release");

      // Vector walk: apply at falling edge, sample 5 ns after rising edge
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {pol_sel, latch_en, pwr_save, ref_div, fb_div} = VEC[i][12:8];
         @(posedge clk);
         #5;
         check("R2 R3 R5 R6 R11 pump1_oe", i, pump1_oe,  VEC[i][7]);
         check("R2 R3 R5 pump1_val",       i, pump1_val, VEC[i][6]);
         check("R7 R8 pump2_oe",           i, pump2_oe,  VEC[i][5]);
         check("R7 pump2_val",             i, pump2_val, VEC[i][4]);
         check("R2 R3 R4 R5 cmp_dn",       i, cmp_dn,    VEC[i][3]);
         check("R2 R3 R4 R5 cmp_up_n",     i, cmp_up_n,  VEC[i][2]);
         check("R9 mon_out",               i, mon_out,   VEC[i][1]);
         check("R10 lock_det",             i, lock_det,  VEC[i][0]);
      end

      // R1: reset in the middle of an active comparison
      @(negedge clk);
      ref_div = 1'b0;
      @(negedge clk);
      ref_div = 1'b1;
      @(posedge clk);
      #5;
      check("R1 pre-reset pump1_oe", -1, pump1_oe, 1'b1);
      rst_n = 1'b0;
      #2;
      check_idle("R1 mid-run reset");
      @(negedge clk);
      rst_n = 1'b1;
      ref_div = 1'b0;

      // R9: monitor follows inputs with no clock delay
      @(negedge clk);
      pol_sel = 1'b0; fb_div = 1'b1; ref_div = 1'b0;
      #1;
      check("R9 mon fb", -1, mon_out, 1'b1);
      pol_sel = 1'b1;
      #1;
      check("R9 mon ref", -1, mon_out, 1'b0);

      // R8: power save raised while a pump is driving
      @(negedge clk);
      fb_div = 1'b0;
      @(negedge clk);
      fb_div = 1'b1;
      @(posedge clk);
      #5;
      check("R3 before power save pump1_oe", -1, pump1_oe, 1'b1);
      pwr_save = 1'b1;
      #1;
      check("R8 pump1_oe in power save", -1, pump1_oe, 1'b0);
      check("R8 pump2_oe in power save", -1, pump2_oe, 1'b0);
      @(posedge clk);
      #5;
      check("R8 detector cleared", -1, cmp_dn, 1'b0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule